// File: doc/BRIEF.md
# Repeated Multiply-Accumulate Engine

This block runs a signed dot product over two element arrays in memory. It gets one command that carries two start addresses, an iteration count, an element size, a 96-bit running sum and a pair of incoming flags. For each iteration it fetches one element from array A and then one from array B. It multiplies them as signed values and folds the 64-bit product into the sum. The sum is kept as a 64-bit unsigned low word plus a 32-bit signed high word. When the count runs out, the block derives an overflow flag and a sign flag from the high word. It then returns the updated addresses, the count, the sum and the flags.

A second command kind clamps a sum that has overflowed. The clamp uses the incoming overflow and sign flags. A negative sign clamps to the largest positive 64-bit value. A non-negative sign clamps to the most negative one, so the direction follows the inverted sign. Every command returns its results in the same way. A one-cycle `done` pulse marks them, and they stay on the result ports until the next command is accepted.

Commands use a valid/ready handshake. `cmd_ready` is high only while the engine is idle, and the command fields are sampled only in the accepting cycle. Memory reads use a request/response handshake. The engine raises `rd_valid` together with the address and size. It holds all three steady until the memory raises `rd_ready`, and `rd_data` must be valid in that same cycle. The memory can hold the engine back for any number of cycles by keeping `rd_ready` low.

Top module: `rmac_engine`

## Requirements
- R1: A multiply-accumulate command with a count of zero issues no reads. It returns the addresses, count, sum and both flags exactly as given, with `done` high in the cycle after acceptance.
- R2: After a command with a count of N > 0, the sum {high, low} equals the starting {high, low} plus the N products of element pairs, with all values taken as 96-bit two's complement.
- R3: Size code 0 selects bytes, 1 selects 16-bit halves, and 2 or 3 select 32-bit words. `rd_size` carries the command's code unchanged. An element is taken from the low bits of `rd_data` and sign-extended, so bits above the element size have no effect.
- R4: When a non-negative product makes the low word wrap, the high word rises by one. When a negative product makes the low word rise as an unsigned value, the high word falls by one. Otherwise the high word is unchanged.
- R5: A command with a count above zero clears overflow when it starts. At the end, overflow is 1 exactly when the high word is neither all zeros nor all ones.
- R6: At the end of a command with a count above zero, the sign flag equals bit 31 of the final high word.
- R7: Each iteration reads A at its current address and then B at its current address. Both addresses then advance by 1, 2 or 4 for size codes 0, 1 and 2/3, with 32-bit wrap.
- R8: A clamp command with overflow set and sign set returns high 0x00000000 and low 0x7FFFFFFF_FFFFFFFF. With overflow set and sign clear, it returns high 0xFFFFFFFF and low 0x80000000_00000000. Addresses, count and flags pass through unchanged.
- R9: A clamp command with overflow clear returns the sum unchanged.
- R10: The count drops by one per iteration and is zero at the end of a command with a count above zero.
- R11: While `rd_valid` is high and `rd_ready` is low, `rd_valid`, `rd_addr` and `rd_size` hold their values. `done` pulses once per accepted command.
- R12: After reset, `cmd_ready` is 1, `rd_valid` and `done` are 0, and all result ports are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command taken when valid |
| cmd_op | input | 1 | 0 multiply-accumulate, 1 clamp |
| cmd_size | input | 2 | Element size code |
| cmd_ptr_a | input | ADDR_W | Start address of array A |
| cmd_ptr_b | input | ADDR_W | Start address of array B |
| cmd_count | input | CNT_W | Iteration count |
| cmd_acc_lo | input | 64 | Starting low word of the sum |
| cmd_acc_hi | input | 32 | Starting signed high word of the sum |
| cmd_ovf | input | 1 | Incoming overflow flag |
| cmd_sign | input | 1 | Incoming sign flag |
| rd_valid | output | 1 | Read request |
| rd_ready | input | 1 | Read accepted, data present |
| rd_addr | output | ADDR_W | Read byte address |
| rd_size | output | 2 | Read size code |
| rd_data | input | 32 | Read data, element right-aligned |
| done | output | 1 | One-cycle result strobe |
| res_ptr_a | output | ADDR_W | Updated address A |
| res_ptr_b | output | ADDR_W | Updated address B |
| res_count | output | CNT_W | Remaining count |
| res_acc_lo | output | 64 | Low word of the sum |
| res_acc_hi | output | 32 | High word of the sum |
| res_ovf | output | 1 | Overflow flag |
| res_sign | output | 1 | Sign flag |

## Verification
The hold property on the read port only holds if the memory side samples `rd_ready` against a pending request. The responder therefore raises `rd_ready` only while `rd_valid` is high, and it randomises the stall length. The pass-through properties compare results with command fields from the accepting cycle. To match this, the driver changes command fields only while `cmd_valid` is low or the engine is idle. The memory contents are never changed while a command runs, so the reference sums built before issue stay correct. The stimulus covers all four size codes, with random bits above each element.

// File: rtl/rmac_pkg.sv
package rmac_pkg;

  localparam int ELEM_W = 32;

  typedef enum logic {
    OP_MAC = 1'b0,
    OP_SAT = 1'b1
  } rmac_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_A,
    ST_RD_B,
    ST_MUL,
    ST_ACC,
    ST_FLAG,
    ST_FIN
  } rmac_state_e;

  // Sign-extend the right-aligned element selected by the size code.
  function automatic logic [ELEM_W-1:0] elem_extend(input logic [ELEM_W-1:0] raw,
                                                     input logic [1:0]        sz);
    case (sz)
      2'd0:    return {{(ELEM_W-8){raw[7]}}, raw[7:0]};
      2'd1:    return {{(ELEM_W-16){raw[15]}}, raw[15:0]};
      default: return raw;
    endcase
  endfunction

  // Byte step between consecutive elements.
  function automatic logic [2:0] elem_stride(input logic [1:0] sz);
    case (sz)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/rmac_mul.sv
module rmac_mul #(
  parameter int IN_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic [IN_W-1:0]     opa,
  input  logic [IN_W-1:0]     opb,
  output logic [2*IN_W-1:0]   prod
);

  localparam int OUT_W = 2 * IN_W;

  logic signed [OUT_W-1:0] wide_a;
  logic signed [OUT_W-1:0] wide_b;

  always_comb begin
    wide_a = {{IN_W{opa[IN_W-1]}}, opa};
    wide_b = {{IN_W{opb[IN_W-1]}}, opb};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  prod <= '0;
    else if (en) prod <= wide_a * wide_b;
  end

endmodule

// File: rtl/rmac_accum.sv
module rmac_accum #(
  parameter int LO_W = 64,
  parameter int HI_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [LO_W-1:0] load_lo,
  input  logic [HI_W-1:0] load_hi,
  input  logic            add_en,
  input  logic [LO_W-1:0] addend,
  output logic [LO_W-1:0] lo,
  output logic [HI_W-1:0] hi
);

  localparam logic [HI_W-1:0] HI_ONE = HI_W'(1);

  logic [LO_W-1:0] sum;
  logic            addend_neg;
  logic            carry_up;
  logic            borrow_down;
  logic [HI_W-1:0] hi_next;

  // The low word wraps unsigned; the high word tracks the lost carry or borrow.
  always_comb begin
    sum         = lo + addend;
    addend_neg  = addend[LO_W-1];
    carry_up    = !addend_neg && (sum < lo);
    borrow_down = addend_neg && (sum > lo);
    hi_next     = hi;
    if (carry_up)         hi_next = hi + HI_ONE;
    else if (borrow_down) hi_next = hi - HI_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo <= '0;
      hi <= '0;
    end else if (load) begin
      lo <= load_lo;
      hi <= load_hi;
    end else if (add_en) begin
      lo <= sum;
      hi <= hi_next;
    end
  end

  // R4: a non-negative addend never lowers the high word, a negative one never raises it
  p_carry_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (add_en && !load && !addend[LO_W-1]) |=> (hi == $past(hi) || hi == $past(hi) + HI_ONE));

  p_borrow_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (add_en && !load && addend[LO_W-1]) |=> (hi == $past(hi) || hi == $past(hi) - HI_ONE));

endmodule

// File: rtl/rmac_sat.sv
module rmac_sat #(
  parameter int LO_W = 64,
  parameter int HI_W = 32
) (
  input  logic            ovf,
  input  logic            sign,
  input  logic [LO_W-1:0] lo_in,
  input  logic [HI_W-1:0] hi_in,
  output logic [LO_W-1:0] lo_out,
  output logic [HI_W-1:0] hi_out
);

  always_comb begin
    lo_out = lo_in;
    hi_out = hi_in;
    if (ovf) begin
      if (sign) begin
        hi_out = '0;
        lo_out = {1'b0, {(LO_W-1){1'b1}}};
      end else begin
        hi_out = '1;
        lo_out = {1'b1, {(LO_W-1){1'b0}}};
      end
    end
  end

endmodule

// File: rtl/rmac_engine.sv
module rmac_engine
  import rmac_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic                cmd_op,
  input  logic [1:0]          cmd_size,
  input  logic [ADDR_W-1:0]   cmd_ptr_a,
  input  logic [ADDR_W-1:0]   cmd_ptr_b,
  input  logic [CNT_W-1:0]    cmd_count,
  input  logic [2*ELEM_W-1:0] cmd_acc_lo,
  input  logic [ELEM_W-1:0]   cmd_acc_hi,
  input  logic                cmd_ovf,
  input  logic                cmd_sign,
  output logic                rd_valid,
  input  logic                rd_ready,
  output logic [ADDR_W-1:0]   rd_addr,
  output logic [1:0]          rd_size,
  input  logic [ELEM_W-1:0]   rd_data,
  output logic                done,
  output logic [ADDR_W-1:0]   res_ptr_a,
  output logic [ADDR_W-1:0]   res_ptr_b,
  output logic [CNT_W-1:0]    res_count,
  output logic [2*ELEM_W-1:0] res_acc_lo,
  output logic [ELEM_W-1:0]   res_acc_hi,
  output logic                res_ovf,
  output logic                res_sign
);

  localparam int LO_W = 2 * ELEM_W;
  localparam int HI_W = ELEM_W;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  rmac_state_e       state;
  logic [1:0]        size_q;
  logic [ADDR_W-1:0] ptr_a_q;
  logic [ADDR_W-1:0] ptr_b_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              ovf_q;
  logic              sign_q;
  logic [ELEM_W-1:0] opa_q;
  logic [ELEM_W-1:0] opb_q;

  logic              accept;
  logic              is_sat;
  logic              loop_start;
  logic [ADDR_W-1:0] stride;
  logic              hi_wide;
  logic [LO_W-1:0]   prod;
  logic [LO_W-1:0]   sat_lo;
  logic [HI_W-1:0]   sat_hi;
  logic [LO_W-1:0]   load_lo;
  logic [HI_W-1:0]   load_hi;
  logic [LO_W-1:0]   acc_lo;
  logic [HI_W-1:0]   acc_hi;

  assign cmd_ready  = (state == ST_IDLE);
  assign accept     = cmd_valid && cmd_ready;
  assign is_sat     = (rmac_op_e'(cmd_op) == OP_SAT);
  assign loop_start = accept && !is_sat && (cmd_count != '0);
  assign stride     = ADDR_W'(elem_stride(size_q));
  assign hi_wide    = !((acc_hi == '0) || (acc_hi == '1));

  assign load_lo = is_sat ? sat_lo : cmd_acc_lo;
  assign load_hi = is_sat ? sat_hi : cmd_acc_hi;

  rmac_sat #(.LO_W(LO_W), .HI_W(HI_W)) u_sat (
    .ovf    (cmd_ovf),
    .sign   (cmd_sign),
    .lo_in  (cmd_acc_lo),
    .hi_in  (cmd_acc_hi),
    .lo_out (sat_lo),
    .hi_out (sat_hi)
  );

  rmac_mul #(.IN_W(ELEM_W)) u_mul (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (state == ST_MUL),
    .opa   (opa_q),
    .opb   (opb_q),
    .prod  (prod)
  );

  rmac_accum #(.LO_W(LO_W), .HI_W(HI_W)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .load_lo (load_lo),
    .load_hi (load_hi),
    .add_en  (state == ST_ACC),
    .addend  (prod),
    .lo      (acc_lo),
    .hi      (acc_hi)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      size_q  <= '0;
      ptr_a_q <= '0;
      ptr_b_q <= '0;
      cnt_q   <= '0;
      ovf_q   <= 1'b0;
      sign_q  <= 1'b0;
      opa_q   <= '0;
      opb_q   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            size_q  <= cmd_size;
            ptr_a_q <= cmd_ptr_a;
            ptr_b_q <= cmd_ptr_b;
            cnt_q   <= cmd_count;
            sign_q  <= cmd_sign;
            ovf_q   <= loop_start ? 1'b0 : cmd_ovf;
            state   <= loop_start ? ST_RD_A : ST_FIN;
          end
        end
        ST_RD_A: begin
          if (rd_ready) begin
            opa_q <= elem_extend(rd_data, size_q);
            state <= ST_RD_B;
          end
        end
        ST_RD_B: begin
          if (rd_ready) begin
            opb_q <= elem_extend(rd_data, size_q);
            state <= ST_MUL;
          end
        end
        ST_MUL: state <= ST_ACC;
        ST_ACC: begin
          ptr_a_q <= ptr_a_q + stride;
          ptr_b_q <= ptr_b_q + stride;
          cnt_q   <= cnt_q - CNT_ONE;
          state   <= (cnt_q == CNT_ONE) ? ST_FLAG : ST_RD_A;
        end
        ST_FLAG: begin
          ovf_q  <= hi_wide;
          sign_q <= acc_hi[HI_W-1];
          state  <= ST_FIN;
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign rd_valid   = (state == ST_RD_A) || (state == ST_RD_B);
  assign rd_addr    = (state == ST_RD_B) ? ptr_b_q : ptr_a_q;
  assign rd_size    = size_q;
  assign done       = (state == ST_FIN);
  assign res_ptr_a  = ptr_a_q;
  assign res_ptr_b  = ptr_b_q;
  assign res_count  = cnt_q;
  assign res_acc_lo = acc_lo;
  assign res_acc_hi = acc_hi;
  assign res_ovf    = ovf_q;
  assign res_sign   = sign_q;

  // R1: zero count returns the command unchanged on the next cycle
  p_zero_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !is_sat && cmd_count == '0) |=>
      (done && res_acc_lo == $past(cmd_acc_lo) && res_acc_hi == $past(cmd_acc_hi) &&
       res_ovf == $past(cmd_ovf) && res_sign == $past(cmd_sign) && res_count == '0));

  // R5: overflow is cleared as a counted command starts
  p_ovf_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    loop_start |=> !res_ovf);

  // R6: final sign follows the high word's top bit
  p_sign_final_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FLAG) |=> (res_sign == res_acc_hi[HI_W-1]));

  // R7: both addresses advance by one element per iteration
  p_ptr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACC) |=> (res_ptr_a == $past(res_ptr_a) + $past(stride) &&
                           res_ptr_b == $past(res_ptr_b) + $past(stride)));

  // R8: clamp direction is opposite to the incoming sign
  p_sat_clamp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_sat && cmd_ovf) |=> ((res_acc_hi == '0) == $past(cmd_sign)));

  // R9: clamp without overflow keeps the sum
  p_sat_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_sat && !cmd_ovf) |=>
      (res_acc_lo == $past(cmd_acc_lo) && res_acc_hi == $past(cmd_acc_hi)));

  // R10: count drops by exactly one per iteration
  p_count_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACC) |=> (res_count == $past(res_count) - CNT_ONE));

  // R11: a stalled read request holds its address and size
  p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr) && $stable(rd_size)));

  // R11: done is a single-cycle pulse
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/rmac_engine_tb_top.sv
module rmac_engine_tb_top;
  import rmac_pkg::*;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic        cmd_op = 1'b0;
  logic [1:0]  cmd_size = '0;
  logic [31:0] cmd_ptr_a = '0;
  logic [31:0] cmd_ptr_b = '0;
  logic [31:0] cmd_count = '0;
  logic [63:0] cmd_acc_lo = '0;
  logic [31:0] cmd_acc_hi = '0;
  logic        cmd_ovf = 1'b0;
  logic        cmd_sign = 1'b0;
  logic        rd_valid;
  logic        rd_ready = 1'b0;
  logic [31:0] rd_addr;
  logic [1:0]  rd_size;
  logic [31:0] rd_data = '0;
  logic        done;
  logic [31:0] res_ptr_a;
  logic [31:0] res_ptr_b;
  logic [31:0] res_count;
  logic [63:0] res_acc_lo;
  logic [31:0] res_acc_hi;
  logic        res_ovf;
  logic        res_sign;

  rmac_engine dut_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_size(cmd_size),
    .cmd_ptr_a(cmd_ptr_a), .cmd_ptr_b(cmd_ptr_b), .cmd_count(cmd_count),
    .cmd_acc_lo(cmd_acc_lo), .cmd_acc_hi(cmd_acc_hi), .cmd_ovf(cmd_ovf), .cmd_sign(cmd_sign),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_size(rd_size),
    .rd_data(rd_data), .done(done),
    .res_ptr_a(res_ptr_a), .res_ptr_b(res_ptr_b), .res_count(res_count),
    .res_acc_lo(res_acc_lo), .res_acc_hi(res_acc_hi), .res_ovf(res_ovf), .res_sign(res_sign)
  );

  typedef struct packed {
    logic [31:0] pa;
    logic [31:0] pb;
    logic [31:0] cnt;
    logic [31:0] hi;
    logic [63:0] lo;
    logic        ovf;
    logic        sign;
  } exp_t;

  exp_t        exp_q[$];
  string       tag_q[$];
  logic [31:0] addr_q[$];
  logic [1:0]  cur_size = '0;
  logic [7:0]  mem [0:255];
  int          n_chk = 0;
  int          n_bad = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [95:0] act, input logic [95:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_word(input logic [31:0] addr);
    logic [7:0] b;
    b = addr[7:0];
    return {mem[b + 8'd3], mem[b + 8'd2], mem[b + 8'd1], mem[b]};
  endfunction

  function automatic logic signed [31:0] ref_elem(input logic [31:0] addr, input logic [1:0] sz);
    logic [31:0] w;
    w = mem_word(addr);
    case (sz)
      2'd0:    return {{24{w[7]}}, w[7:0]};
      2'd1:    return {{16{w[15]}}, w[15:0]};
      default: return w;
    endcase
  endfunction

  // Memory responder: random stalls, random bits above the element (R3).
  always @(negedge clk) begin
    logic [31:0] w;
    logic [31:0] a;
    if (rst_n && rd_valid && ($urandom_range(0, 2) != 0)) begin
      w = mem_word(rd_addr);
      case (cur_size)
        2'd0:    w = {$urandom_range(0, 32'hFFFFFF), w[7:0]};
        2'd1:    w = {16'($urandom), w[15:0]};
        default: ;
      endcase
      rd_data  = w;
      rd_ready = 1'b1;
      if (addr_q.size() == 0) begin
        check(1'b0, "R7 R11", "unexpected read", 96'(rd_addr), 96'(0));
      end else begin
        a = addr_q.pop_front();
        check(rd_addr == a, "R7 R11", "read address order", 96'(rd_addr), 96'(a));
      end
      check(rd_size == cur_size, "R3", "read size code", 96'(rd_size), 96'(cur_size));
    end else begin
      rd_ready = 1'b0;
      rd_data  = $urandom;
    end
  end

  // Monitor: pop the scoreboard on every done pulse.
  always @(negedge clk) begin
    exp_t  e;
    string t;
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R11", "done without command", 96'(1), 96'(0));
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({res_acc_hi, res_acc_lo} == {e.hi, e.lo}, t, "sum",
              {res_acc_hi, res_acc_lo}, {e.hi, e.lo});
        check(res_ptr_a == e.pa && res_ptr_b == e.pb, t, "addresses",
              96'({res_ptr_a, res_ptr_b}), 96'({e.pa, e.pb}));
        check(res_count == e.cnt, t, "count", 96'(res_count), 96'(e.cnt));
        check({res_ovf, res_sign} == {e.ovf, e.sign}, t, "flags ovf,sign",
              96'({res_ovf, res_sign}), 96'({e.ovf, e.sign}));
      end
    end
  end

  task automatic run_cmd(input bit sat, input logic [1:0] sz, input logic [31:0] pa,
                         input logic [31:0] pb, input logic [31:0] cnt, input logic [63:0] lo,
                         input logic [31:0] hi, input bit ov, input bit sg, input string tag);
    exp_t               e;
    logic signed [95:0] acc;
    logic signed [31:0] ea;
    logic signed [31:0] eb;
    logic signed [63:0] p;
    logic [31:0]        st;
    st = (sz == 2'd0) ? 32'd1 : (sz == 2'd1) ? 32'd2 : 32'd4;
    e.pa = pa; e.pb = pb; e.cnt = cnt; e.lo = lo; e.hi = hi; e.ovf = ov; e.sign = sg;
    if (sat) begin
      if (ov && sg)  begin e.hi = 32'h0;        e.lo = 64'h7FFF_FFFF_FFFF_FFFF; end
      if (ov && !sg) begin e.hi = 32'hFFFF_FFFF; e.lo = 64'h8000_0000_0000_0000; end
    end else if (cnt != 0) begin
      acc = {hi, lo};
      for (int i = 0; i < int'(cnt); i++) begin
        ea = ref_elem(pa + 32'(i) * st, sz);
        eb = ref_elem(pb + 32'(i) * st, sz);
        addr_q.push_back(pa + 32'(i) * st);
        addr_q.push_back(pb + 32'(i) * st);
        p   = ea * eb;
        acc = acc + p;
      end
      e.pa   = pa + cnt * st;
      e.pb   = pb + cnt * st;
      e.cnt  = 0;
      e.hi   = acc[95:64];
      e.lo   = acc[63:0];
      e.ovf  = !(acc[95:64] == 32'h0 || acc[95:64] == 32'hFFFF_FFFF);
      e.sign = acc[95];
    end
    exp_q.push_back(e);
    tag_q.push_back(tag);
    cur_size = sz;
    while (!cmd_ready) @(negedge clk);
    cmd_op = sat; cmd_size = sz; cmd_ptr_a = pa; cmd_ptr_b = pb; cmd_count = cnt;
    cmd_acc_lo = lo; cmd_acc_hi = hi; cmd_ovf = ov; cmd_sign = sg;
    cmd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12: reset state
    check(cmd_ready && !rd_valid && !done, "R12", "idle handshake",
          96'({cmd_ready, rd_valid, done}), 96'(3'b100));
    check(res_acc_lo == 0 && res_acc_hi == 0 && res_count == 0 && !res_ovf && !res_sign,
          "R12", "result ports", {res_acc_hi, res_acc_lo}, 96'(0));

    // R1: zero count is a no-op, flags included
    run_cmd(1'b0, 2'd2, 32'h0000_1234, 32'h0000_5678, 32'd0, 64'h1111_2222_3333_4444,
            32'h0000_0005, 1'b1, 1'b1, "R1");

    // R2 R3: bytes with random upper bits on the bus
    run_cmd(1'b0, 2'd0, 32'h10, 32'h20, 32'd4, 64'd0, 32'd0, 1'b0, 1'b0, "R2 R3 R7 R10");

    // R4: negative product borrows into the high word
    mem[8'h40] = 8'hFD; mem[8'h41] = 8'hFF;
    mem[8'h50] = 8'h04; mem[8'h51] = 8'h00;
    run_cmd(1'b0, 2'd1, 32'h40, 32'h50, 32'd1, 64'd5, 32'd0, 1'b1, 1'b0, "R4 R5 R6");

    // R4 R5: positive product carries out of the low word, overflow set
    mem[8'h60] = 8'h00; mem[8'h61] = 8'h01; mem[8'h62] = 8'h00; mem[8'h63] = 8'h00;
    mem[8'h70] = 8'h01; mem[8'h71] = 8'h00; mem[8'h72] = 8'h00; mem[8'h73] = 8'h00;
    run_cmd(1'b0, 2'd2, 32'h60, 32'h70, 32'd1, 64'hFFFF_FFFF_FFFF_FFF0, 32'd0, 1'b0, 1'b1,
            "R4 R5 R6");

    // R7: 32-bit address wrap, size code 3 behaves as words
    run_cmd(1'b0, 2'd3, 32'hFFFF_FFF8, 32'hFFFF_FFFC, 32'd3, 64'd7, 32'hFFFF_FFFF, 1'b0, 1'b0,
            "R2 R3 R7");

    // R8 R9: clamp variants
    run_cmd(1'b1, 2'd0, 32'hA, 32'hB, 32'd9, 64'h0123_4567_89AB_CDEF, 32'h0000_0003, 1'b1, 1'b1,
            "R8");
    run_cmd(1'b1, 2'd1, 32'hC, 32'hD, 32'd2, 64'h0123_4567_89AB_CDEF, 32'hFFFF_FF00, 1'b1, 1'b0,
            "R8");
    run_cmd(1'b1, 2'd2, 32'hE, 32'hF, 32'd5, 64'hDEAD_BEEF_0000_0001, 32'h0000_0042, 1'b0, 1'b1,
            "R9");

    // Mixed random commands
    for (int k = 0; k < 24; k++) begin
      logic [31:0] h;
      h = (k % 3 == 0) ? 32'h0 : (k % 3 == 1) ? 32'hFFFF_FFFF : 32'($urandom);
      run_cmd(1'b0, 2'($urandom_range(0, 3)), 32'($urandom), 32'($urandom),
              32'($urandom_range(1, 6)), {32'($urandom), 32'($urandom)}, h,
              1'($urandom), 1'($urandom), "R2 R4 R5 R6 R7 R10");
    end
    run_cmd(1'b1, 2'd0, 32'h1, 32'h2, 32'd0, 64'h5, 32'h7, 1'b1, 1'b1, "R8");

    repeat (5) @(negedge clk);
    check(addr_q.size() == 0, "R7", "reads outstanding", 96'(addr_q.size()), 96'(0));
    finish_run();
  end

endmodule